// File: doc/BRIEF.md
# Periodic SPI Temperature Word Reader

This block is an SPI master that repeatedly fetches a 16-bit temperature word from a serial sensor and presents it on a parallel bus. A one-cycle valid strobe marks each new word. A programmable divider produces an enable tick, and that tick paces every serial event. The SCLK period is two ticks long, with SCLK idle low. The block drives MOSI while SCLK is low and samples MISO on the falling SCLK edge.

After reset the master runs a one-time wake-up frame with chip select held low. The frame carries a run of zero bits, then a run of one bits, then the read command, then the data window. After that first frame it never returns to the wake-up bits. It loops forever through three phases: command, data window, and an idle gap with chip select high. The captured word is copied into a separate output register only once the whole word has arrived. The output register keeps its value until the next capture.

Top module: `temp_spi_reader`

## Requirements
- R1: While reset is asserted, cs_n is 1, sclk is 0, mosi is 0, temp_word is 0 and temp_valid is 0.
- R2: While cs_n is low, every SCLK high level and every SCLK low level lasts exactly CLK_DIV clock cycles. This includes the low level that follows the fall of cs_n.
- R3: sclk is 0 whenever cs_n is 1, and sclk is 0 in the cycle in which cs_n falls.
- R4: The first frame after reset has PRE_LEN+PRE_LEN+CMD_W+DATA_W SCLK rising edges (88 by default). At those rising edges MOSI is 0 for the first PRE_LEN bits and 1 for the next PRE_LEN bits. It then carries CMD_WORD, most significant bit first, and is 0 for the DATA_W data bits.
- R5: Every later frame has CMD_W+DATA_W rising edges: CMD_WORD, MSB first, then DATA_W zero bits, with no wake-up bits. Between frames cs_n stays high for exactly 2*HOLD_LEN*CLK_DIV clock cycles.
- R6: MOSI never changes in the cycle in which SCLK rises.
- R7: temp_word is sampled on the falling SCLK edges of the data window, MSB first. It equals the DATA_W bits the sensor drove, including the pattern 16'b0000101100010000.
- R8: temp_valid is high for exactly one cycle per capture. temp_word changes only in a cycle in which temp_valid is high.
- R9: temp_valid is never asserted before the data window of the first frame has ended. In particular it is never asserted during the wake-up bits.
- R10: temp_valid is high in the clock cycle that follows the cycle in which cs_n rises at the end of the data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to sensor |
| miso | input | 1 | Serial data from sensor |
| temp_word | output | DATA_W | Last captured temperature word |
| temp_valid | output | 1 | One-cycle strobe for a new temp_word |

## Verification
Each SCLK level is due exactly CLK_DIV cycles after the previous one, and the gap between frames is due 2*HOLD_LEN*CLK_DIV cycles after cs_n rises. The valid strobe, together with the new word, is due one cycle after that rise. The bench samples all outputs on the falling clock edge and counts cycles from the rise or fall of cs_n, so each result is compared in the exact cycle it is due. A sensor model drives MISO on rising SCLK, so the data is stable long before the sampling edge. It outside the window it drives ones, which exposes any misaligned sample.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ZERO,
      ST_ONES,
      ST_CMD,
      ST_RECV,
      ST_GAP
   } seq_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/tsr_tick.sv
module tsr_tick #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
         assign tick = &cnt;
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt <= '0;
            else if (cnt == CW'(DIV - 1))  cnt <= '0;
            else                           cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/tsr_seq.sv
module tsr_seq
   import tsr_pkg::*;
#(
   parameter int PRE_LEN  = 32,
   parameter int CMD_W    = 8,
   parameter int DATA_W   = 16,
   parameter int HOLD_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output seq_t st,
   output logic sclk,
   output logic cs_n,
   output logic bit_fall,
   output logic phase_end,
   output logic cmd_load
);
   localparam int MAXL = max4(PRE_LEN, CMD_W, DATA_W, HOLD_LEN);
   localparam int CW   = (MAXL > 2) ? $clog2(MAXL) : 1;

   logic          half;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last_idx;
   seq_t          nxt;
   logic          active;

   always_comb begin
      unique case (st)
         ST_ZERO, ST_ONES: last_idx = CW'(PRE_LEN - 1);
         ST_CMD:           last_idx = CW'(CMD_W - 1);
         ST_RECV:          last_idx = CW'(DATA_W - 1);
         default:          last_idx = CW'(HOLD_LEN - 1);
      endcase
   end

   always_comb begin
      unique case (st)
         ST_IDLE: nxt = ST_ZERO;
         ST_ZERO: nxt = ST_ONES;
         ST_ONES: nxt = ST_CMD;
         ST_CMD:  nxt = ST_RECV;
         ST_RECV: nxt = ST_GAP;
         default: nxt = ST_CMD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         half <= 1'b0;
         cnt  <= '0;
      end else if (tick) begin
         if (st == ST_IDLE) begin
            st   <= nxt;
            half <= 1'b0;
            cnt  <= '0;
         end else begin
            half <= ~half;
            if (half) begin
               if (cnt == last_idx) begin
                  cnt <= '0;
                  st  <= nxt;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   assign active    = (st == ST_ZERO) || (st == ST_ONES) || (st == ST_CMD) || (st == ST_RECV);
   assign cs_n      = ~active;
   assign sclk      = active & half;
   assign bit_fall  = tick & half & (st != ST_IDLE);
   assign phase_end = (cnt == last_idx);
   assign cmd_load  = bit_fall & phase_end & ((st == ST_ONES) || (st == ST_GAP));
endmodule

// File: rtl/tsr_tx.sv
module tsr_tx #(
   parameter int                W    = 8,
   parameter logic [W-1:0]      WORD = 8'h5A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic shift,
   output logic msb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= WORD;
      else if (shift) sr <= {sr[W-2:0], 1'b0};
   end

   assign msb = sr[W-1];
endmodule

// File: rtl/tsr_rx.sv
module tsr_rx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         last,
   input  logic         din,
   output logic [W-1:0] word,
   output logic         done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         done <= 1'b0;
      end else begin
         if (en) word <= {word[W-2:0], din};
         done <= en & last;
      end
   end
endmodule

// File: rtl/temp_spi_reader.sv
module temp_spi_reader
   import tsr_pkg::*;
#(
   parameter int                 CLK_DIV  = 8,
   parameter int                 PRE_LEN  = 32,
   parameter int                 CMD_W    = 8,
   parameter int                 DATA_W   = 16,
   parameter int                 HOLD_LEN = 4,
   parameter logic [CMD_W-1:0]   CMD_WORD = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso,
   output logic [DATA_W-1:0] temp_word,
   output logic              temp_valid
);
   generate
      if (CLK_DIV < 2)  begin : g_bad_div  $error("CLK_DIV must be at least 2"); end
      if (CMD_W < 2)    begin : g_bad_cmd  $error("CMD_W must be at least 2"); end
      if (DATA_W < 2)   begin : g_bad_dat  $error("DATA_W must be at least 2"); end
      if (PRE_LEN < 1)  begin : g_bad_pre  $error("PRE_LEN must be at least 1"); end
      if (HOLD_LEN < 1) begin : g_bad_hold $error("HOLD_LEN must be at least 1"); end
   endgenerate

   logic              tick;
   seq_t              st;
   logic              bit_fall;
   logic              phase_end;
   logic              cmd_load;
   logic              tx_msb;
   logic [DATA_W-1:0] rx_word;
   logic              rx_done;

   tsr_tick #(.DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   tsr_seq #(
      .PRE_LEN (PRE_LEN),
      .CMD_W   (CMD_W),
      .DATA_W  (DATA_W),
      .HOLD_LEN(HOLD_LEN)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .st       (st),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .bit_fall (bit_fall),
      .phase_end(phase_end),
      .cmd_load (cmd_load)
   );

   tsr_tx #(.W(CMD_W), .WORD(CMD_WORD)) u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cmd_load),
      .shift(bit_fall && (st == ST_CMD)),
      .msb  (tx_msb)
   );

   tsr_rx #(.W(DATA_W)) u_rx (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (bit_fall && (st == ST_RECV)),
      .last (phase_end),
      .din  (miso),
      .word (rx_word),
      .done (rx_done)
   );

   always_comb begin
      unique case (st)
         ST_ONES: mosi = 1'b1;
         ST_CMD:  mosi = tx_msb;
         default: mosi = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_word  <= '0;
         temp_valid <= 1'b0;
      end else begin
         temp_valid <= rx_done;
         if (rx_done) temp_word <= rx_word;
      end
   end
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk,
   input logic              cs_n,
   input logic              mosi,
   input logic [DATA_W-1:0] temp_word,
   input logic              temp_valid
);
   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   p_cs_fall_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !sclk);

   p_mosi_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));

   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      temp_valid |=> !temp_valid);

   p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !temp_valid |-> $stable(temp_word));

   p_valid_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      temp_valid |-> (cs_n && $past(cs_n) && !$past(cs_n, 2)));
endmodule

bind temp_spi_reader tsr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk      (sclk),
   .cs_n      (cs_n),
   .mosi      (mosi),
   .temp_word (temp_word),
   .temp_valid(temp_valid)
);

// File: tb/temp_spi_reader_bench.sv
module temp_spi_reader_bench;
   localparam int         CLK_DIV  = 8;
   localparam int         PRE_LEN  = 32;
   localparam int         CMD_W    = 8;
   localparam int         DATA_W   = 16;
   localparam int         HOLD_LEN = 4;
   localparam logic [7:0] CMD      = 8'h5A;
   localparam int         NF       = 10;
   localparam int         LIMIT    = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              miso = 1'b1;
   logic              sclk, cs_n, mosi;
   logic [DATA_W-1:0] temp_word;
   logic              temp_valid;

   logic [DATA_W-1:0] words [NF];
   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   temp_spi_reader #(
      .CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN), .CMD_W(CMD_W),
      .DATA_W(DATA_W), .HOLD_LEN(HOLD_LEN), .CMD_WORD(CMD)
   ) u_temp_spi_reader (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .temp_word(temp_word), .temp_valid(temp_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic exp_mosi(input bit first, input int idx);
      int k;
      k = idx;
      if (first) begin
         if (k < PRE_LEN) return 1'b0;
         if (k < 2 * PRE_LEN) return 1'b1;
         k = k - 2 * PRE_LEN;
      end
      if (k < CMD_W) return CMD[CMD_W-1-k];
      return 1'b0;
   endfunction

   // sensor model: drives each data bit on the rising SCLK edge
   initial begin : sensor
      int fr, n, off;
      fr = 0;
      forever begin
         @(negedge cs_n);
         n = 0;
         off = (fr == 0) ? (2 * PRE_LEN + CMD_W) : CMD_W;
         while (!cs_n) begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) break;
            if (n >= off && n < off + DATA_W) miso = words[fr % NF][DATA_W-1-(n-off)];
            else miso = 1'b1;
            n++;
         end
         fr++;
      end
   end

   initial begin : main
      int seed_v, cur_fr, nbits, mosi_bad, run, gap, rose_cyc, nvalid, r2_bad, r3_bad;
      logic p_cs, p_sclk, p_valid;
      logic [DATA_W-1:0] p_word;
      bit done;
      seed_v = $urandom(32'd4711);
      words[0] = 16'b0000101100010000;
      words[1] = 16'h0000;
      words[2] = 16'hFFFF;
      words[3] = 16'h8001;
      words[4] = 16'h0BD8;
      for (int i = 5; i < NF; i++) words[i] = DATA_W'($urandom);

      repeat (3) @(negedge clk);
      chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 serial pins",
          {cs_n, sclk, mosi}, 3'b100);
      chk(temp_word === '0 && temp_valid === 1'b0, "R1 word/valid",
          {temp_word, temp_valid}, 0);
      rst_n = 1'b1;

      cur_fr = -1; nbits = 0; mosi_bad = 0; run = 0; gap = 0; rose_cyc = -100;
      nvalid = 0; r2_bad = 0; r3_bad = 0; done = 1'b0;
      p_cs = 1'b1; p_sclk = 1'b0; p_valid = 1'b0; p_word = '0;

      for (int cyc = 0; cyc < LIMIT && !done; cyc++) begin
         @(negedge clk);
         if (p_cs && !cs_n) begin
            if (cur_fr >= 0)
               chk(gap == 2 * HOLD_LEN * CLK_DIV, "R5 gap", gap, 2 * HOLD_LEN * CLK_DIV);
            cur_fr++; nbits = 0; mosi_bad = 0; run = 1;
            if (sclk) r3_bad++;
         end else if (!cs_n) begin
            if (sclk != p_sclk) begin
               if (run != CLK_DIV) r2_bad++;
               run = 1;
            end else run++;
         end
         if (cs_n && sclk) r3_bad++;
         if (!cs_n && sclk && !p_sclk) begin
            if (mosi !== exp_mosi(cur_fr == 0, nbits)) mosi_bad++;
            nbits++;
         end
         if (!p_cs && cs_n) begin
            rose_cyc = cyc; gap = 1;
            if (cur_fr == 0) begin
               chk(nbits == 2 * PRE_LEN + CMD_W + DATA_W, "R4 bit count", nbits,
                   2 * PRE_LEN + CMD_W + DATA_W);
               chk(mosi_bad == 0, "R4 mosi pattern", mosi_bad, 0);
            end else begin
               chk(nbits == CMD_W + DATA_W, "R5 bit count", nbits, CMD_W + DATA_W);
               chk(mosi_bad == 0, "R5 mosi pattern", mosi_bad, 0);
            end
         end else if (cs_n) gap++;
         if (temp_valid) begin
            chk(cur_fr >= 0 && rose_cyc >= 0, "R9 early valid", cur_fr, 0);
            chk(cyc == rose_cyc + 1, "R10 valid timing", cyc - rose_cyc, 1);
            if (cur_fr >= 0)
               chk(temp_word === words[cur_fr % NF], "R7 captured word",
                   temp_word, words[cur_fr % NF]);
            chk(!p_valid, "R8 single pulse", p_valid, 0);
            nvalid++;
            if (nvalid >= NF) done = 1'b1;
         end else if (temp_word !== p_word) begin
            chk(1'b0, "R8 word changed without valid", temp_word, p_word);
         end
         p_cs = cs_n; p_sclk = sclk; p_valid = temp_valid; p_word = temp_word;
      end

      chk(done, "watchdog: all captures", nvalid, NF);
      chk(r2_bad == 0, "R2 sclk level length", r2_bad, 0);
      chk(r3_bad == 0, "R3 sclk idle with cs_n high", r3_bad, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule